// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Triggers

This block is a bank of general-purpose pins behind a small register interface whose data width equals the pin count (16 by default). Software sets each pin's direction, output value and alternate-function select, and can read the synchronised level of every pin at any time, whatever its direction. The alternate-function bits are only brought out on a port; the peripherals behind them and the pad drivers lie outside this block.

Each pin can also raise an interrupt. Three per-pin registers select the trigger. A type bit picks edge or level. A separate polarity bit applies in each of the two modes. Pin inputs pass through a two-flop synchroniser. An event on an unmasked pin sets a sticky status bit, and the bank interrupt line is the OR of all status bits. Software clears status bits by writing zeros to them. A pin in level mode keeps its bit set for as long as its active level is present.

Top module: `gpio_irq_bank`

## Requirements
- R1: Register 0x0 holds direction. A bit of 1 makes that pin an output: `pin_oe` bit is 1. A bit of 0 makes it an input. The register reads back what was written.
- R2: Register 0x1 holds output data and drives `pin_out`. Register 0x2 holds the alternate-function select and drives `pin_alt`. Both read back what was written.
- R3: Register 0x8 is read-only and returns the level of each pin after the two-flop synchroniser, for input and output pins alike.
- R4: Register 0x4 holds the trigger type. A bit of 1 selects edge mode. With the edge-polarity bit (register 0x5) at 1, a rising edge sets the status bit and a falling edge does not.
- R5: In edge mode with the edge-polarity bit at 0, a falling edge sets the status bit and a rising edge does not.
- R6: A type bit of 0 selects level mode. With the level-polarity bit (register 0x6) at 1 a high level sets the status bit, and at 0 a low level sets it. While the active level persists, the bit is set again even right after software clears it.
- R7: Register 0x3 holds the mask. A mask bit of 1 stops the pin from setting its status bit. Setting every mask bit blocks every pin.
- R8: Register 0x7 holds the sticky status. On a write, each status bit written 0 is cleared and each bit written 1 is kept, so writing zero clears all of them. `irq` is 1 exactly when some status bit is set.
- R9: After a synchronous reset, all mask bits are 1, and direction, output, alternate-function, trigger, polarity and status registers and `irq` are 0.
- R10: `bus_rdata` returns the register selected by `bus_addr` one clock later. Unmapped addresses (0x9 to 0xF) read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data to the pads |
| pin_oe | output | 16 | Output enable per pin (1 = output) |
| pin_alt | output | 16 | Alternate-function select per pin |
| irq | output | 1 | Combined bank interrupt |

## Verification
The hardest case to reach is a level-mode pin whose active level is still present when software clears its status. The status bit must stay set, and it must fall only after the pin has gone inactive and a second clear arrives. The bench gets there by a fixed sequence, run for every pin in all four trigger modes:
- arm the trigger with all pins masked;
- settle the pin in its inactive state;
- clear the status and unmask only the pin under test;
- toggle that pin and issue clears around the release.

Edge modes also toggle the pin back, to confirm that the opposite edge is ignored.

// File: rtl/gpio_irq_bank_pkg.sv
package gpio_irq_bank_pkg;
  typedef enum logic [3:0] {
    RA_DIR  = 4'h0,
    RA_OUT  = 4'h1,
    RA_ALT  = 4'h2,
    RA_MASK = 4'h3,
    RA_TYPE = 4'h4,
    RA_EPOL = 4'h5,
    RA_LPOL = 4'h6,
    RA_STAT = 4'h7,
    RA_LVL  = 4'h8
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_bank_sync.sv
module gpio_irq_bank_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_bank_detect.sv
module gpio_irq_bank_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] epol,
  input  logic [W-1:0] lpol,
  input  logic [W-1:0] mask,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    assign rise     = lvl[g] & ~prev[g];
    assign fall     = ~lvl[g] & prev[g];
    assign edge_hit = epol[g] ? rise : fall;
    assign lvl_hit  = lpol[g] ? lvl[g] : ~lvl[g];
    assign evt[g]   = ~mask[g] & (edge_sel[g] ? edge_hit : lvl_hit);
  end
endmodule

// File: rtl/gpio_irq_bank_regs.sv
module gpio_irq_bank_regs
  import gpio_irq_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] alt_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] type_q,
  output logic [W-1:0] epol_q,
  output logic [W-1:0] lpol_q,
  output logic [W-1:0] stat_q,
  output logic         irq_q
);
  logic [W-1:0] keep, stat_n, rd_mux;

  always_comb begin
    keep   = (wr && addr == RA_STAT) ? wdata : '1;
    stat_n = (stat_q & keep) | evt;
  end

  always_comb begin
    case (addr)
      RA_DIR:  rd_mux = dir_q;
      RA_OUT:  rd_mux = out_q;
      RA_ALT:  rd_mux = alt_q;
      RA_MASK: rd_mux = mask_q;
      RA_TYPE: rd_mux = type_q;
      RA_EPOL: rd_mux = epol_q;
      RA_LPOL: rd_mux = lpol_q;
      RA_STAT: rd_mux = stat_q;
      RA_LVL:  rd_mux = lvl;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      alt_q  <= '0;
      mask_q <= '1;
      type_q <= '0;
      epol_q <= '0;
      lpol_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr) begin
        case (addr)
          RA_DIR:  dir_q  <= wdata;
          RA_OUT:  out_q  <= wdata;
          RA_ALT:  alt_q  <= wdata;
          RA_MASK: mask_q <= wdata;
          RA_TYPE: type_q <= wdata;
          RA_EPOL: epol_q <= wdata;
          RA_LPOL: lpol_q <= wdata;
          default: ;
        endcase
      end
      stat_q <= stat_n;
      irq_q  <= |stat_n;
      rdata  <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic [3:0]      bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pin_alt,
  output logic            irq
);
  logic [PINS-1:0] lvl_w, evt_w, mask_w, type_w, epol_w, lpol_w, stat_w;

  gpio_irq_bank_sync #(.W(PINS), .STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(lvl_w)
  );

  gpio_irq_bank_detect #(.W(PINS)) det_i (
    .clk(clk), .rst(rst), .lvl(lvl_w), .edge_sel(type_w), .epol(epol_w),
    .lpol(lpol_w), .mask(mask_w), .evt(evt_w)
  );

  gpio_irq_bank_regs #(.W(PINS)) regs_i (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .evt(evt_w), .lvl(lvl_w), .rdata(bus_rdata), .dir_q(pin_oe),
    .out_q(pin_out), .alt_q(pin_alt), .mask_q(mask_w), .type_q(type_w),
    .epol_q(epol_w), .lpol_q(lpol_w), .stat_q(stat_w), .irq_q(irq)
  );
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic [3:0]      bus_addr,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pin_out,
  input logic            irq,
  input logic [PINS-1:0] stat_q,
  input logic [PINS-1:0] mask_q
);
  // R7: a newly set status bit needs its mask bit clear in the cycle before
  a_r7_masked_never_sets: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  // R8: status bits fall only on a status-register write
  a_r8_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 4'h7) |=> (($past(stat_q) & ~stat_q) == '0));

  // R8: no status bits means no interrupt
  a_r8_irq_low_when_empty: assert property (@(posedge clk) disable iff (rst)
    (stat_q == '0) |-> !irq);

  // R1: direction changes only when its register is written
  a_r1_oe_holds: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 4'h0) |=> $stable(pin_oe));

  // R2: output data changes only when its register is written
  a_r2_out_holds: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 4'h1) |=> $stable(pin_out));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PINS(PINS)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq),
  .stat_q(stat_w), .mask_q(mask_w)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  localparam int PINS = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0;
  logic [3:0]      bus_addr = 4'h0;
  logic [PINS-1:0] bus_wdata = '0;
  logic [PINS-1:0] bus_rdata;
  logic [PINS-1:0] pins = '0;
  logic [PINS-1:0] pin_out, pin_oe, pin_alt;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.PINS(PINS)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt), .irq(irq)
  );

  task automatic chk(input logic [PINS-1:0] act, input logic [PINS-1:0] exp,
                     input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [PINS-1:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [PINS-1:0] v;
    logic [PINS-1:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h1E78;

    idle(3);
    @(negedge clk) rst = 1'b0;

    // R9: reset values
    rd(4'h3, v); chk(v, 16'hFFFF, "R9 mask reset");
    rd(4'h0, v); chk(v, 16'h0000, "R9 dir reset");
    rd(4'h7, v); chk(v, 16'h0000, "R9 status reset");
    chk(pin_oe, '0, "R9 pin_oe reset");
    chk(pin_out, '0, "R9 pin_out reset");
    chk(pin_alt, '0, "R9 pin_alt reset");
    chk({15'd0, irq}, '0, "R9 irq reset");

    // R1 R2: register write and readback
    for (int p = 0; p < 4; p++) begin
      wr(4'h0, pats[p]);       chk(pin_oe, pats[p], "R1 pin_oe");
      rd(4'h0, v);             chk(v, pats[p], "R1 dir readback");
      wr(4'h1, ~pats[p]);      chk(pin_out, ~pats[p], "R2 pin_out");
      rd(4'h1, v);             chk(v, ~pats[p], "R2 out readback");
      wr(4'h2, pats[(p+1)%4]); chk(pin_alt, pats[(p+1)%4], "R2 pin_alt");
      rd(4'h2, v);             chk(v, pats[(p+1)%4], "R2 alt readback");
    end

    // R3: live level readable for either direction
    for (int p = 0; p < 4; p++) begin
      wr(4'h0, (p % 2 == 0) ? 16'h0000 : 16'hFFFF);
      pins = pats[p]; idle(3);
      rd(4'h8, v); chk(v, pats[p], "R3 pin level");
    end
    for (int i = 0; i < PINS; i++) begin
      pins = 16'h1 << i; idle(3);
      rd(4'h8, v); chk(v, 16'h1 << i, "R3 walking one");
    end
    wr(4'h0, 16'h0000);

    // R10: unmapped addresses read zero
    for (int a = 9; a < 16; a++) begin
      rd(a[3:0], v); chk(v, 16'h0000, "R10 unmapped read");
    end

    // R7: every pin masked, edge ignored
    pins = '0;
    wr(4'h4, 16'hFFFF); wr(4'h5, 16'hFFFF); wr(4'h3, 16'hFFFF);
    idle(4); wr(4'h7, 16'h0000);
    pins = 16'hFFFF; idle(4);
    rd(4'h7, v); chk(v, 16'h0000, "R7 all masked");
    chk({15'd0, irq}, '0, "R7 irq masked");

    // R8: selective clear of pins 0 and 1 (rising mode)
    pins = '0; idle(4); wr(4'h7, 16'h0000);
    wr(4'h3, 16'hFFFC);
    pins = 16'h0003; idle(4);
    rd(4'h7, v); chk(v, 16'h0003, "R8 two bits set");
    wr(4'h7, 16'h0002);
    rd(4'h7, v); chk(v, 16'h0002, "R8 partial clear");
    chk({15'd0, irq}, 16'h1, "R8 irq still high");
    wr(4'h7, 16'h0000);
    rd(4'h7, v); chk(v, 16'h0000, "R8 clear all");
    chk({15'd0, irq}, '0, "R8 irq low");

    // R4 R5 R6: every pin in every trigger mode
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < PINS; i++) begin
        logic [PINS-1:0] bit_i;
        string tg;
        bit_i = 16'h1 << i;
        tg = (m == 0) ? "R4 rising" : (m == 1) ? "R5 falling" :
             (m == 2) ? "R6 level high" : "R6 level low";
        wr(4'h3, 16'hFFFF);
        wr(4'h4, (m < 2) ? 16'hFFFF : 16'h0000);
        wr(4'h5, (m == 0) ? 16'hFFFF : 16'h0000);
        wr(4'h6, (m == 2) ? 16'hFFFF : 16'h0000);
        pins = (m == 1 || m == 3) ? bit_i : '0;
        idle(4);
        wr(4'h7, 16'h0000);
        wr(4'h3, ~bit_i);
        rd(4'h7, v); chk(v, 16'h0000, {tg, " idle"});
        pins = pins ^ bit_i; idle(4);
        rd(4'h7, v); chk(v, bit_i, {tg, " detect"});
        chk({15'd0, irq}, 16'h1, "R8 irq on event");
        if (m < 2) begin
          wr(4'h7, 16'h0000);
          rd(4'h7, v); chk(v, 16'h0000, "R8 edge clear");
          pins = pins ^ bit_i; idle(4);
          rd(4'h7, v); chk(v, 16'h0000, {tg, " opposite edge ignored"});
        end else begin
          wr(4'h7, 16'h0000);
          rd(4'h7, v); chk(v, bit_i, "R6 level re-set while active");
          pins = pins ^ bit_i; idle(4);
          wr(4'h7, 16'h0000);
          rd(4'h7, v); chk(v, 16'h0000, "R6 clear after release");
          chk({15'd0, irq}, '0, "R8 irq low after release");
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule